// File: doc/BRIEF.md
# Two-Base Level-1 Translation Table Address Generator

This block turns a 32-bit virtual address into the physical address of its level-1 translation descriptor. It holds two table base registers, a 3-bit split control value N and a 32-bit domain access register. All four are reached through a small register port.

For each address the block chooses a base. Base 1 is used when any of the top N address bits is set. Otherwise base 0 is used. The chosen base is then masked to its alignment, and the section index is merged into it. The alignment of base 0 depends on N. Base 1 is always aligned to 16 KB.

When a level-1 descriptor comes back from memory, the block also decodes it. It gives the descriptor type, the domain number, and the 2-bit permission that the domain access register holds for that domain. The fetch from memory, the later stages of the walk, any caching of translations and fault generation all belong to the surrounding logic.

Top module: `ttb_addr_gen`

## Requirements
- R1: A write to the control register (select 2) stores only write-data bits [2:0] as N. A read of select 2 returns N, zero-extended to 32 bits.
- R2: Select 0 is base 0, select 1 is base 1 and select 3 is the domain access register. Each of these reads back the full 32-bit value written to it. Selects 4 to 7 read as zero. Reads are combinational.
- R3: `use_base1_o` is high exactly when any of address bits [31:32-N] is set. When N is 0 it is always low.
- R4: When base 0 is chosen, the base part of the descriptor address is base 0 ANDed with the inverse of (0x3FFF >> N).
- R5: When base 1 is chosen, the base part of the descriptor address is base 1 ANDed with 0xFFFFC000, for every N.
- R6: The descriptor address is the masked base ORed with address bits [31:20] placed at bits [13:2]. Bits [1:0] of the descriptor address are always zero.
- R7: After reset, all four registers read zero, N is 0, and base 0 has 16 KB alignment.
- R8: `desc_type_o` equals descriptor bits [1:0].
- R9: `desc_domain_o` equals descriptor bits [8:5]. `domain_perm_o` is the domain access register field at bits [2d+1:2d], where d is the domain.
- R10: A register write is captured at the clock edge on which `reg_we_i` is high. It affects the outputs from that edge on, and not before it. While `reg_we_i` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Register select: 0 base 0, 1 base 1, 2 control, 3 domain access |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| vaddr_i | input | 32 | Virtual address to translate |
| use_base1_o | output | 1 | High when base 1 is chosen |
| desc_addr_o | output | 32 | Physical address of the level-1 descriptor |
| desc_i | input | 32 | Level-1 descriptor returned from memory |
| desc_type_o | output | 2 | Descriptor type |
| desc_domain_o | output | 4 | Descriptor domain number |
| domain_perm_o | output | 2 | Access permission field for that domain |

## Verification
Read data, base choice, descriptor address and descriptor decode are all combinational. They are due in the same cycle their inputs are driven, so the bench drives at the falling edge and samples 1 ns later. A register write becomes visible only after the next rising edge. The bench therefore checks the old descriptor address before that edge and the new one after it. The vector walk programs N, both bases and an address for each entry, then compares the chosen base and the descriptor address one cycle after the last write.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned CTL_W    = 3;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned IDX_W    = 12;   // section index bits
  localparam int unsigned ALIGN_W  = 14;   // 16 KB table alignment
  localparam int unsigned DOM_W    = 4;
  localparam int unsigned PERM_W   = 2;
  localparam int unsigned TYPE_W   = 2;
  localparam int unsigned DOM_LSB  = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_BASE0 = 3'd0,
    SEL_BASE1 = 3'd1,
    SEL_CTL   = 3'd2,
    SEL_DACR  = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/ttb_regfile.sv
module ttb_regfile
  import ttb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CTL_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] base0_o,
  output logic [AW-1:0] base1_o,
  output logic [CW-1:0] ctl_o,
  output logic [AW-1:0] dacr_o
);
  logic [AW-1:0] base0_q, base1_q, dacr_q;
  logic [CW-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base0_q <= '0;
      base1_q <= '0;
      ctl_q   <= '0;
      dacr_q  <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_BASE0: base0_q <= wdata_i;
        SEL_BASE1: base1_q <= wdata_i;
        SEL_CTL:   ctl_q   <= wdata_i[CW-1:0];
        SEL_DACR:  dacr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_BASE0: rdata_o = base0_q;
      SEL_BASE1: rdata_o = base1_q;
      SEL_CTL:   rdata_o = {{(AW-CW){1'b0}}, ctl_q};
      SEL_DACR:  rdata_o = dacr_q;
      default:   rdata_o = '0;
    endcase
  end

  assign base0_o = base0_q;
  assign base1_o = base1_q;
  assign ctl_o   = ctl_q;
  assign dacr_o  = dacr_q;

  p_ctl_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CTL) |=> (ctl_q == $past(wdata_i[CW-1:0])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(base0_q) && $stable(base1_q) && $stable(ctl_q) && $stable(dacr_q)));

  p_base_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_BASE1) |=> (base1_q == $past(wdata_i)));
endmodule

// File: rtl/ttb_select.sv
module ttb_select
  import ttb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CTL_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned LW = ALIGN_W
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] base0_i,
  input  logic [AW-1:0] base1_i,
  input  logic [CW-1:0] ctl_i,
  output logic          use_b1_o,
  output logic [AW-1:0] desc_addr_o
);
  localparam logic [AW-1:0] LOW_ONES = {{(AW-LW){1'b0}}, {LW{1'b1}}};
  localparam int unsigned   PAD_W    = AW - IW - 2;

  logic [AW-1:0] split_mask, b0_mask, base_sel, index;

  // top-N region mask and base 0 alignment both follow N
  assign split_mask = ~({AW{1'b1}} >> ctl_i);
  assign b0_mask    = ~(LOW_ONES >> ctl_i);
  assign use_b1_o   = |(vaddr_i & split_mask);
  assign base_sel   = use_b1_o ? (base1_i & ~LOW_ONES) : (base0_i & b0_mask);
  assign index      = {{PAD_W{1'b0}}, vaddr_i[AW-1 -: IW], 2'b00};
  assign desc_addr_o = base_sel | index;
endmodule

// File: rtl/ttb_desc_decode.sv
module ttb_desc_decode
  import ttb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DOM_W,
  parameter int unsigned PW = PERM_W,
  parameter int unsigned TW = TYPE_W,
  parameter int unsigned DL = DOM_LSB
) (
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] dacr_i,
  output logic [TW-1:0] type_o,
  output logic [DW-1:0] domain_o,
  output logic [PW-1:0] perm_o
);
  localparam int unsigned NDOM = 1 << DW;

  logic [PW-1:0] fields [NDOM];

  for (genvar g = 0; g < NDOM; g++) begin : g_field
    assign fields[g] = dacr_i[g*PW +: PW];
  end

  assign type_o   = desc_i[TW-1:0];
  assign domain_o = desc_i[DL +: DW];
  assign perm_o   = fields[domain_o];
endmodule

// File: rtl/ttb_addr_gen.sv
module ttb_addr_gen
  import ttb_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [SEL_W-1:0]      reg_sel_i,
  input  logic [ADDR_W-1:0]     reg_wdata_i,
  output logic [ADDR_W-1:0]     reg_rdata_o,
  input  logic [ADDR_W-1:0]     vaddr_i,
  output logic                  use_base1_o,
  output logic [ADDR_W-1:0]     desc_addr_o,
  input  logic [ADDR_W-1:0]     desc_i,
  output logic [TYPE_W-1:0]     desc_type_o,
  output logic [DOM_W-1:0]      desc_domain_o,
  output logic [PERM_W-1:0]     domain_perm_o
);
  logic [ADDR_W-1:0] base0, base1, dacr;
  logic [CTL_W-1:0]  ctl;

  ttb_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base0_o (base0),
    .base1_o (base1),
    .ctl_o   (ctl),
    .dacr_o  (dacr)
  );

  ttb_select u_sel (
    .vaddr_i     (vaddr_i),
    .base0_i     (base0),
    .base1_i     (base1),
    .ctl_i       (ctl),
    .use_b1_o    (use_base1_o),
    .desc_addr_o (desc_addr_o)
  );

  ttb_desc_decode u_dec (
    .desc_i   (desc_i),
    .dacr_i   (dacr),
    .type_o   (desc_type_o),
    .domain_o (desc_domain_o),
    .perm_o   (domain_perm_o)
  );

  p_n0_base0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl == '0) |-> !use_base1_o);

  p_b1_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_base1_o |-> (desc_addr_o[ALIGN_W-1:0] == {vaddr_i[ADDR_W-1 -: IDX_W], 2'b00}));

  p_low_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_addr_o[1:0] == 2'b00);

  p_n0_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl == '0) |-> (desc_addr_o[ADDR_W-1:ALIGN_W] == base0[ADDR_W-1:ALIGN_W]));

  p_dacr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dacr == '0) |-> (domain_perm_o == '0));
endmodule

// File: tb/ttb_addr_gen_tb_top.sv
module ttb_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] vaddr = '0;
  logic        use_b1;
  logic [31:0] daddr;
  logic [31:0] desc = '0;
  logic [1:0]  dtype;
  logic [3:0]  ddom;
  logic [1:0]  dperm;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ttb_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .vaddr_i(vaddr),
    .use_base1_o(use_b1), .desc_addr_o(daddr), .desc_i(desc),
    .desc_type_o(dtype), .desc_domain_o(ddom), .domain_perm_o(dperm)
  );

  localparam int NV = 7;
  localparam logic [2:0]  V_N  [NV] = '{3'd0, 3'd1, 3'd1, 3'd7, 3'd7, 3'd4, 3'd4};
  localparam logic [31:0] V_B0 [NV] = '{32'h12345678, 32'h12345678, 32'h12345678,
                                        32'h12345678, 32'h12345678, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] V_B1 [NV] = '{32'hABCDEFFF, 32'hABCDEFFF, 32'hABCDEFFF,
                                        32'hABCDEFFF, 32'hABCDEFFF, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] V_VA [NV] = '{32'hFFF00000, 32'h80100000, 32'h7FF00000,
                                        32'h01000000, 32'h02000000, 32'h0FF00000, 32'h10000000};
  localparam logic [31:0] V_EA [NV] = '{32'h12347FFC, 32'hABCDE004, 32'h12345FFC,
                                        32'h12345640, 32'hABCDC080, 32'hFFFFFFFC, 32'h00000400};
  localparam logic        V_EB [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input string req, input logic [31:0] exp);
    @(negedge clk);
    sel = s;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(3'd0, "R7 base0", 32'h0);
    rd(3'd1, "R7 base1", 32'h0);
    rd(3'd2, "R7 ctl", 32'h0);
    rd(3'd3, "R7 dacr", 32'h0);
    vaddr = 32'hFFF00000;
    #1 check("R7 reset addr", daddr, 32'h00003FFC);
    check("R7 reset use_b1", {31'b0, use_b1}, 32'h0);

    // vector walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(3'd2, {29'b0, V_N[i]});
      wr(3'd0, V_B0[i]);
      wr(3'd1, V_B1[i]);
      @(negedge clk);
      vaddr = V_VA[i];
      #1;
      check("R3 base choice", {31'b0, use_b1}, {31'b0, V_EB[i]});
      check(V_EB[i] ? "R5 R6 desc addr" : "R4 R6 desc addr", daddr, V_EA[i]);
    end

    // R1 control keeps low 3 bits
    wr(3'd2, 32'hFFFFFFFA);
    rd(3'd2, "R1 ctl readback", 32'h2);
    // R2 readback and unused selects
    wr(3'd0, 32'hDEADBEEF);
    rd(3'd0, "R2 base0 readback", 32'hDEADBEEF);
    wr(3'd1, 32'hCAFEF00D);
    rd(3'd1, "R2 base1 readback", 32'hCAFEF00D);
    rd(3'd5, "R2 sel5 zero", 32'h0);
    rd(3'd7, "R2 sel7 zero", 32'h0);

    // R10 no write while we low
    @(negedge clk);
    we = 1'b0; sel = 3'd0; wdata = 32'h11111111;
    @(negedge clk);
    #1 check("R10 we low hold", rdata, 32'hDEADBEEF);

    // R10 write visible only after the edge
    wr(3'd2, 32'h0);
    @(negedge clk);
    vaddr = 32'h00100000;
    we = 1'b1; sel = 3'd0; wdata = 32'h00008000;
    #1 check("R10 before edge", daddr, 32'hDEADBEEF & 32'hFFFFC000 | 32'h4);
    @(negedge clk);
    we = 1'b0;
    #1 check("R10 after edge", daddr, 32'h00008004);

    // R8 R9 descriptor decode
    wr(3'd3, 32'h80000006);
    desc = 32'h000001E1;
    #1;
    check("R8 type", {30'b0, dtype}, 32'h1);
    check("R9 domain", {28'b0, ddom}, 32'hF);
    check("R9 perm d15", {30'b0, dperm}, 32'h2);
    desc = 32'h00000022;
    #1;
    check("R8 type", {30'b0, dtype}, 32'h2);
    check("R9 perm d1", {30'b0, dperm}, 32'h1);
    desc = 32'h00000003;
    #1;
    check("R9 perm d0", {30'b0, dperm}, 32'h2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule